// File: doc/BRIEF.md
# Projection-based human region classifier

This block takes the binary motion mask of one frame, delivered as a raster-order bit stream, and decides whether the moving region in that frame looks like a person standing upright. While the frame streams in, it keeps two profiles: for every row, the number of set pixels in that row, and for every column, the number of set pixels in that column. Profile entries below a programmable level are treated as noise. The first and last surviving column give the horizontal span of the region. The first and last surviving row give its vertical span.

When the frame has ended, a scan of both profiles runs in parallel, one index per cycle. The block then forms the bounding box, its width, height and area, and applies three tests. The area must exceed a threshold. The height-to-width ratio must lie inside a programmable window, checked by cross-multiplication so that no divider is needed. The box must be taller than it is wide. A one-cycle result strobe carries the box, the area, an empty flag and the human flag. The profile storage has two banks, so the next frame may start streaming while the previous one is still being scanned.

Top module: `hrc_region_classifier`

## Requirements
- R1: After reset, `res_valid`, `res_human`, `res_empty`, `res_area`, `res_width` and `res_height` are all 0.
- R2: Column x of the column profile counts the accepted pixels with `pix_bit`=1 whose column index is x. Row y of the row profile counts the same pixels by row index. Both profiles are cleared by the accepted pixel that carries `pix_sof`, which is pixel (0,0) and is itself counted. A frame's result therefore depends only on that frame's pixels.
- R3: `res_x_first`/`res_x_last` are the lowest and highest column whose count is at least `cfg_proj_thr`. `res_y_first`/`res_y_last` are the same for rows. `res_width` = x_last − x_first + 1 and `res_height` = y_last − y_first + 1.
- R4: `res_area` equals `res_width` × `res_height`.
- R5: If no column or no row reaches the threshold, `res_empty`=1 and `res_human`=0, and every box, size and area field is 0.
- R6: `res_human`=1 requires `res_area` strictly greater than `cfg_area_thr`. An area equal to the threshold is rejected.
- R7: `res_human`=1 requires height×`cfg_ratio_den` ≥ width×`cfg_ratio_min` and height×`cfg_ratio_den` ≤ width×`cfg_ratio_max`. Both bounds are inclusive.
- R8: `res_human`=1 requires height > width. A square box is rejected.
- R9: `res_valid` is a single-cycle pulse. With the default 128×128 frame, it is high in the 130th cycle after the clock edge that accepts the `pix_eof` pixel.
- R10: All five thresholds are sampled at the edge that accepts the `pix_eof` pixel. Later changes do not affect that frame's result.
- R11: The next frame's `pix_sof` pixel may be accepted in the cycle right after `pix_eof`. Both frames still produce correct results, in order.
- R12: Cycles with `pix_valid`=0 are ignored, whatever `pix_bit`, `pix_sof` and `pix_eof` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Mask pixel present this cycle |
| pix_bit | input | 1 | Mask value, 1 = motion |
| pix_sof | input | 1 | First pixel of a frame, position (0,0) |
| pix_eof | input | 1 | Last pixel of a frame |
| cfg_proj_thr | input | DW (8) | Minimum profile count that marks a row or column as part of the region |
| cfg_area_thr | input | AREA_W (15) | Area must be strictly above this value |
| cfg_ratio_den | input | RAT_W (8) | Denominator of the aspect window |
| cfg_ratio_min | input | RAT_W (8) | Lower aspect numerator (height/width ≥ min/den) |
| cfg_ratio_max | input | RAT_W (8) | Upper aspect numerator (height/width ≤ max/den) |
| res_valid | output | 1 | One-cycle result strobe |
| res_empty | output | 1 | No region found |
| res_human | output | 1 | Region classified as an upright person |
| res_x_first | output | XW (7) | Leftmost region column |
| res_x_last | output | XW (7) | Rightmost region column |
| res_y_first | output | YW (7) | Top region row |
| res_y_last | output | YW (7) | Bottom region row |
| res_width | output | DW (8) | Box width in pixels |
| res_height | output | DW (8) | Box height in pixels |
| res_area | output | AREA_W (15) | Box area in pixels |

## Verification
The bench targets the inclusive edges, where an off-by-one is easy to make:
- a profile count exactly equal to the projection threshold, which a design using `>` would drop;
- an area exactly equal to the area threshold, which a `>=` comparison would wrongly accept;
- a height on each aspect bound and one just past the upper bound;
- a square box that passes every other test and fails only the upright rule.

An empty frame placed right after a full one shows whether the profiles are cleared at start-of-frame, since stale counts would produce a phantom box. A threshold of zero must give a 128×128 box with width and height of 128, which catches narrow size fields.

Back-to-back frames, threshold changes after end-of-frame, and idle cycles carrying garbage markers and bits cover the remaining hazards. A design without a working second bank, without thresholds latched at end-of-frame, or without gating on the valid strobe would produce a wrong result in one of these frames.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

  // default width of the aspect-window numerators and denominator
  localparam int HRC_RAT_W = 8;

  // profile scanner state
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

endpackage

// File: rtl/hrc_proj_bank.sv
// Double-banked projection profile for one axis: one counter per index.
module hrc_proj_bank #(
  parameter int N     = 128,
  parameter int IW    = $clog2(N),
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,    // accepted pixel
  input  logic             acc_clr,   // accepted pixel opens a frame
  input  logic             acc_hit,   // pixel is set
  input  logic [IW-1:0]    acc_idx,   // index on this axis
  input  logic             wr_bank,
  input  logic             rd_bank,
  input  logic [IW-1:0]    rd_idx,
  output logic [CNT_W-1:0] rd_val
);

  localparam int NB = 2;

  logic [CNT_W-1:0] cnt_q [NB][N];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar i = 0; i < N; i++) begin : g_entry
      logic sel_bank;
      logic sel_idx;
      assign sel_bank = acc_en && (wr_bank == b[0]);
      assign sel_idx  = acc_hit && (acc_idx == IW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[b][i] <= '0;
        end else if (sel_bank) begin
          if (acc_clr)      cnt_q[b][i] <= sel_idx ? CNT_W'(1) : '0;
          else if (sel_idx) cnt_q[b][i] <= cnt_q[b][i] + CNT_W'(1);
        end
      end
    end
  end

  assign rd_val = cnt_q[rd_bank][rd_idx];

endmodule

// File: rtl/hrc_extent_scan.sv
// Walks one profile, one index per cycle, and records the first and last
// index whose count reaches the threshold.
module hrc_extent_scan import hrc_pkg::*; #(
  parameter int N     = 128,
  parameter int IW    = $clog2(N),
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] thr,
  output logic [IW-1:0]    rd_idx,
  input  logic [CNT_W-1:0] rd_val,
  output logic             done,
  output logic             found,
  output logic [IW-1:0]    first,
  output logic [IW-1:0]    last
);

  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  scan_state_e state_q;
  logic [IW-1:0] idx_q;
  logic          hit;
  logic          at_end;

  function automatic logic passes(input logic [CNT_W-1:0] v,
                                  input logic [CNT_W-1:0] t);
    return v >= t;
  endfunction

  assign rd_idx = idx_q;
  assign hit    = passes(rd_val, thr);
  assign at_end = (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      idx_q   <= '0;
      done    <= 1'b0;
      found   <= 1'b0;
      first   <= '0;
      last    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        SCAN_IDLE: begin
          if (start) begin
            state_q <= SCAN_RUN;
            idx_q   <= '0;
            found   <= 1'b0;
            first   <= '0;
            last    <= '0;
          end
        end
        SCAN_RUN: begin
          if (hit) begin
            if (!found) first <= idx_q;
            found <= 1'b1;
            last  <= idx_q;
          end
          if (at_end) begin
            state_q <= SCAN_IDLE;
            done    <= 1'b1;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hrc_classify.sv
// Joins the two scan results, sizes the box and applies the shape tests.
module hrc_classify #(
  parameter int XW     = 7,
  parameter int YW     = 7,
  parameter int DW     = 8,
  parameter int AREA_W = 15,
  parameter int RAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_x,
  input  logic              found_x,
  input  logic [XW-1:0]     x_first,
  input  logic [XW-1:0]     x_last,
  input  logic              done_y,
  input  logic              found_y,
  input  logic [YW-1:0]     y_first,
  input  logic [YW-1:0]     y_last,
  input  logic [AREA_W-1:0] area_thr,
  input  logic [RAT_W-1:0]  ratio_den,
  input  logic [RAT_W-1:0]  ratio_min,
  input  logic [RAT_W-1:0]  ratio_max,
  output logic              res_valid,
  output logic              res_empty,
  output logic              res_human,
  output logic [XW-1:0]     res_x_first,
  output logic [XW-1:0]     res_x_last,
  output logic [YW-1:0]     res_y_first,
  output logic [YW-1:0]     res_y_last,
  output logic [DW-1:0]     res_width,
  output logic [DW-1:0]     res_height,
  output logic [AREA_W-1:0] res_area
);

  localparam int PW = DW + RAT_W;

  function automatic logic [DW-1:0] span(input logic [DW-1:0] lo,
                                          input logic [DW-1:0] hi);
    return hi - lo + DW'(1);
  endfunction

  function automatic logic [AREA_W-1:0] box_area(input logic [DW-1:0] w,
                                                  input logic [DW-1:0] h);
    return AREA_W'(w) * AREA_W'(h);
  endfunction

  function automatic logic ratio_ok(input logic [DW-1:0]    w,
                                    input logic [DW-1:0]    h,
                                    input logic [RAT_W-1:0] den,
                                    input logic [RAT_W-1:0] nmin,
                                    input logic [RAT_W-1:0] nmax);
    logic [PW-1:0] hd, wlo, whi;
    hd  = PW'(h) * PW'(den);
    wlo = PW'(w) * PW'(nmin);
    whi = PW'(w) * PW'(nmax);
    return (hd >= wlo) && (hd <= whi);
  endfunction

  logic seen_x_q, seen_y_q;
  logic have_x, have_y, fire;
  logic empty;
  logic [DW-1:0]     w_c, h_c;
  logic [AREA_W-1:0] a_c;
  logic              human_c;

  assign have_x = done_x || seen_x_q;
  assign have_y = done_y || seen_y_q;
  assign fire   = have_x && have_y;

  assign empty   = !(found_x && found_y);
  assign w_c     = span(DW'(x_first), DW'(x_last));
  assign h_c     = span(DW'(y_first), DW'(y_last));
  assign a_c     = box_area(w_c, h_c);
  assign human_c = !empty && (a_c > area_thr) && (h_c > w_c) &&
                   ratio_ok(w_c, h_c, ratio_den, ratio_min, ratio_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_x_q <= 1'b0;
      seen_y_q <= 1'b0;
    end else if (fire) begin
      seen_x_q <= 1'b0;
      seen_y_q <= 1'b0;
    end else begin
      if (done_x) seen_x_q <= 1'b1;
      if (done_y) seen_y_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_empty   <= 1'b0;
      res_human   <= 1'b0;
      res_x_first <= '0;
      res_x_last  <= '0;
      res_y_first <= '0;
      res_y_last  <= '0;
      res_width   <= '0;
      res_height  <= '0;
      res_area    <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_empty   <= empty;
        res_human   <= human_c;
        res_x_first <= empty ? '0 : x_first;
        res_x_last  <= empty ? '0 : x_last;
        res_y_first <= empty ? '0 : y_first;
        res_y_last  <= empty ? '0 : y_last;
        res_width   <= empty ? '0 : w_c;
        res_height  <= empty ? '0 : h_c;
        res_area    <= empty ? '0 : a_c;
      end
    end
  end

endmodule

// File: rtl/hrc_region_classifier.sv
module hrc_region_classifier import hrc_pkg::*; #(
  parameter int IMG_W  = 128,
  parameter int IMG_H  = 128,
  parameter int RAT_W  = HRC_RAT_W,
  parameter int XW     = $clog2(IMG_W),
  parameter int YW     = $clog2(IMG_H),
  parameter int DW     = $clog2(((IMG_W > IMG_H) ? IMG_W : IMG_H) + 1),
  parameter int AREA_W = $clog2(IMG_W * IMG_H + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              pix_bit,
  input  logic              pix_sof,
  input  logic              pix_eof,
  input  logic [DW-1:0]     cfg_proj_thr,
  input  logic [AREA_W-1:0] cfg_area_thr,
  input  logic [RAT_W-1:0]  cfg_ratio_den,
  input  logic [RAT_W-1:0]  cfg_ratio_min,
  input  logic [RAT_W-1:0]  cfg_ratio_max,
  output logic              res_valid,
  output logic              res_empty,
  output logic              res_human,
  output logic [XW-1:0]     res_x_first,
  output logic [XW-1:0]     res_x_last,
  output logic [YW-1:0]     res_y_first,
  output logic [YW-1:0]     res_y_last,
  output logic [DW-1:0]     res_width,
  output logic [DW-1:0]     res_height,
  output logic [AREA_W-1:0] res_area
);

  localparam logic [XW-1:0] X_END = XW'(IMG_W - 1);

  // named internal events
  logic frame_end;            // accepted end-of-frame pixel
  logic scan_go;              // scanners start
  logic done_x, done_y;       // scanner completion pulses
  logic wsel_q, rsel_q;       // write bank / scanned bank

  logic [XW-1:0] px_q, cur_x;
  logic [YW-1:0] py_q, cur_y;

  logic [DW-1:0]     cfg_proj_q;
  logic [AREA_W-1:0] cfg_area_q;
  logic [RAT_W-1:0]  cfg_den_q, cfg_min_q, cfg_max_q;

  logic [XW-1:0] col_rd_idx;
  logic [YW-1:0] row_rd_idx;
  logic [DW-1:0] col_rd_val, row_rd_val;
  logic          found_x, found_y;
  logic [XW-1:0] x_first, x_last;
  logic [YW-1:0] y_first, y_last;

  assign frame_end = pix_valid && pix_eof;
  assign cur_x     = pix_sof ? '0 : px_q;
  assign cur_y     = pix_sof ? '0 : py_q;

  // raster position and bank control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q    <= '0;
      py_q    <= '0;
      wsel_q  <= 1'b0;
      rsel_q  <= 1'b0;
      scan_go <= 1'b0;
    end else begin
      scan_go <= frame_end;
      if (pix_valid) begin
        if (cur_x == X_END) begin
          px_q <= '0;
          py_q <= cur_y + YW'(1);
        end else begin
          px_q <= cur_x + XW'(1);
          py_q <= cur_y;
        end
      end
      if (frame_end) begin
        rsel_q <= wsel_q;
        wsel_q <= ~wsel_q;
      end
    end
  end

  // thresholds are frozen with the frame they judge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_proj_q <= '0;
      cfg_area_q <= '0;
      cfg_den_q  <= '0;
      cfg_min_q  <= '0;
      cfg_max_q  <= '0;
    end else if (frame_end) begin
      cfg_proj_q <= cfg_proj_thr;
      cfg_area_q <= cfg_area_thr;
      cfg_den_q  <= cfg_ratio_den;
      cfg_min_q  <= cfg_ratio_min;
      cfg_max_q  <= cfg_ratio_max;
    end
  end

  // column profile: indexed by x
  hrc_proj_bank #(.N(IMG_W), .IW(XW), .CNT_W(DW)) u_col_prof (
    .clk(clk), .rst_n(rst_n),
    .acc_en(pix_valid), .acc_clr(pix_sof), .acc_hit(pix_bit),
    .acc_idx(cur_x), .wr_bank(wsel_q), .rd_bank(rsel_q),
    .rd_idx(col_rd_idx), .rd_val(col_rd_val)
  );

  // row profile: indexed by y
  hrc_proj_bank #(.N(IMG_H), .IW(YW), .CNT_W(DW)) u_row_prof (
    .clk(clk), .rst_n(rst_n),
    .acc_en(pix_valid), .acc_clr(pix_sof), .acc_hit(pix_bit),
    .acc_idx(cur_y), .wr_bank(wsel_q), .rd_bank(rsel_q),
    .rd_idx(row_rd_idx), .rd_val(row_rd_val)
  );

  hrc_extent_scan #(.N(IMG_W), .IW(XW), .CNT_W(DW)) u_col_scan (
    .clk(clk), .rst_n(rst_n), .start(scan_go), .thr(cfg_proj_q),
    .rd_idx(col_rd_idx), .rd_val(col_rd_val),
    .done(done_x), .found(found_x), .first(x_first), .last(x_last)
  );

  hrc_extent_scan #(.N(IMG_H), .IW(YW), .CNT_W(DW)) u_row_scan (
    .clk(clk), .rst_n(rst_n), .start(scan_go), .thr(cfg_proj_q),
    .rd_idx(row_rd_idx), .rd_val(row_rd_val),
    .done(done_y), .found(found_y), .first(y_first), .last(y_last)
  );

  hrc_classify #(.XW(XW), .YW(YW), .DW(DW), .AREA_W(AREA_W), .RAT_W(RAT_W)) u_cls (
    .clk(clk), .rst_n(rst_n),
    .done_x(done_x), .found_x(found_x), .x_first(x_first), .x_last(x_last),
    .done_y(done_y), .found_y(found_y), .y_first(y_first), .y_last(y_last),
    .area_thr(cfg_area_q), .ratio_den(cfg_den_q),
    .ratio_min(cfg_min_q), .ratio_max(cfg_max_q),
    .res_valid(res_valid), .res_empty(res_empty), .res_human(res_human),
    .res_x_first(res_x_first), .res_x_last(res_x_last),
    .res_y_first(res_y_first), .res_y_last(res_y_last),
    .res_width(res_width), .res_height(res_height), .res_area(res_area)
  );

endmodule

// File: rtl/hrc_region_classifier_chk.sv
module hrc_region_classifier_chk #(
  parameter int XW     = 7,
  parameter int YW     = 7,
  parameter int DW     = 8,
  parameter int AREA_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic              scan_go,
  input logic              done_x,
  input logic              done_y,
  input logic              wsel_q,
  input logic [AREA_W-1:0] cfg_area_q,
  input logic              res_valid,
  input logic              res_empty,
  input logic              res_human,
  input logic [XW-1:0]     res_x_first,
  input logic [XW-1:0]     res_x_last,
  input logic [YW-1:0]     res_y_first,
  input logic [YW-1:0]     res_y_last,
  input logic [DW-1:0]     res_width,
  input logic [DW-1:0]     res_height,
  input logic [AREA_W-1:0] res_area
);

  // R9: the strobe never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9: end-of-frame launches the scan on the next cycle
  a_r9_scan_launch: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> scan_go);

  // R9: both scans finishing together produce the result next cycle
  a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (done_x && done_y) |=> res_valid);

  // R11: every finished frame hands the write side to the other bank
  a_r11_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (wsel_q != $past(wsel_q)));

  // R5: an empty region is never a person and has no area
  a_r5_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_empty) |-> (!res_human && res_area == '0));

  // R6: a person's box area exceeds the latched area threshold
  a_r6_area_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_human) |-> (res_area > cfg_area_q));

  // R8: a person's box is taller than wide
  a_r8_upright: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_human) |-> (res_height > res_width));

  // R3: a non-empty box has ordered corners and a nonzero size
  a_r3_ordered_box: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_empty) |->
      (res_x_last >= res_x_first && res_y_last >= res_y_first &&
       res_width != '0 && res_height != '0));

endmodule

bind hrc_region_classifier hrc_region_classifier_chk #(
  .XW(XW), .YW(YW), .DW(DW), .AREA_W(AREA_W)
) u_hrc_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .scan_go(scan_go),
  .done_x(done_x), .done_y(done_y), .wsel_q(wsel_q), .cfg_area_q(cfg_area_q),
  .res_valid(res_valid), .res_empty(res_empty), .res_human(res_human),
  .res_x_first(res_x_first), .res_x_last(res_x_last),
  .res_y_first(res_y_first), .res_y_last(res_y_last),
  .res_width(res_width), .res_height(res_height), .res_area(res_area)
);

// File: tb/hrc_region_classifier_test.sv
`timescale 1ns/1ps
module hrc_region_classifier_test;

  localparam int W   = 128;
  localparam int H   = 128;
  localparam int LAT = 130;   // R9: edges from eof acceptance to strobe
  localparam int NF  = 9;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 0, pix_bit = 0, pix_sof = 0, pix_eof = 0;
  logic [7:0]  cfg_proj_thr = 0;
  logic [14:0] cfg_area_thr = 0;
  logic [7:0]  cfg_ratio_den = 0, cfg_ratio_min = 0, cfg_ratio_max = 0;
  logic        res_valid, res_empty, res_human;
  logic [6:0]  res_x_first, res_x_last, res_y_first, res_y_last;
  logic [7:0]  res_width, res_height;
  logic [14:0] res_area;

  always #10 clk = ~clk;   // 50 MHz

  hrc_region_classifier uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_bit(pix_bit),
    .pix_sof(pix_sof), .pix_eof(pix_eof), .cfg_proj_thr(cfg_proj_thr),
    .cfg_area_thr(cfg_area_thr), .cfg_ratio_den(cfg_ratio_den),
    .cfg_ratio_min(cfg_ratio_min), .cfg_ratio_max(cfg_ratio_max),
    .res_valid(res_valid), .res_empty(res_empty), .res_human(res_human),
    .res_x_first(res_x_first), .res_x_last(res_x_last),
    .res_y_first(res_y_first), .res_y_last(res_y_last),
    .res_width(res_width), .res_height(res_height), .res_area(res_area)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 0;

  // frame shape: rectangle plus optional sparse noise
  int rx0, rx1, ry0, ry1, noise_on, noise_seed;
  // thresholds for the frame being built
  int t_proj, t_area, t_den, t_min, t_max;

  // expected results per frame
  int e_empty[NF], e_human[NF], e_x0[NF], e_x1[NF], e_y0[NF], e_y1[NF];
  int e_w[NF], e_h[NF], e_a[NF], eof_cyc[NF];
  int rcount = 0;
  bit prev_v = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pix_at(input int x, input int y);
    bit in_rect, speck;
    in_rect = (x >= rx0) && (x <= rx1) && (y >= ry0) && (y <= ry1);
    speck   = noise_on != 0 && (((x * 37 + y * 101 + noise_seed * 13) % 97) == 0);
    return in_rect || speck;
  endfunction

  // bench model of the requirements (R2..R8)
  task automatic calc_expected(input int f);
    int colc[W];
    int rowc[H];
    int xa, xb, ya, yb, wd, ht;
    for (int i = 0; i < W; i++) colc[i] = 0;
    for (int i = 0; i < H; i++) rowc[i] = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        if (pix_at(x, y)) begin colc[x]++; rowc[y]++; end
    xa = -1; xb = -1; ya = -1; yb = -1;
    for (int i = W - 1; i >= 0; i--) if (colc[i] >= t_proj) xa = i;
    for (int i = 0; i < W; i++)      if (colc[i] >= t_proj) xb = i;
    for (int i = H - 1; i >= 0; i--) if (rowc[i] >= t_proj) ya = i;
    for (int i = 0; i < H; i++)      if (rowc[i] >= t_proj) yb = i;
    if (xa < 0 || ya < 0) begin
      e_empty[f] = 1; e_human[f] = 0;
      e_x0[f] = 0; e_x1[f] = 0; e_y0[f] = 0; e_y1[f] = 0;
      e_w[f] = 0; e_h[f] = 0; e_a[f] = 0;
    end else begin
      wd = xb - xa + 1;
      ht = yb - ya + 1;
      e_empty[f] = 0;
      e_x0[f] = xa; e_x1[f] = xb; e_y0[f] = ya; e_y1[f] = yb;
      e_w[f] = wd; e_h[f] = ht; e_a[f] = wd * ht;
      e_human[f] = (wd * ht > t_area) && (ht > wd) &&
                   !(ht * t_den < wd * t_min) && !(ht * t_den > wd * t_max);
    end
  endtask

  task automatic apply_cfg();
    cfg_proj_thr  = 8'(t_proj);
    cfg_area_thr  = 15'(t_area);
    cfg_ratio_den = 8'(t_den);
    cfg_ratio_min = 8'(t_min);
    cfg_ratio_max = 8'(t_max);
  endtask

  // streams one frame; leaves the eof pixel driven. gap_mod>0 inserts
  // invalid cycles carrying garbage (R12).
  task automatic send_frame(input int f, input int gap_mod);
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        if (gap_mod > 0) begin
          while (($urandom % gap_mod) == 0) begin
            @(negedge clk);
            pix_valid = 0;
            pix_bit = 1'($urandom);
            pix_sof = 1'($urandom);
            pix_eof = 1'($urandom);
          end
        end
        @(negedge clk);
        if (x == 0 && y == 0) apply_cfg();
        pix_valid = 1;
        pix_bit   = pix_at(x, y);
        pix_sof   = (x == 0 && y == 0);
        pix_eof   = (x == W - 1 && y == H - 1);
      end
    end
    eof_cyc[f] = cyc + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 0; pix_sof = 0; pix_eof = 0; pix_bit = 0;
    end
  endtask

  task automatic shape(input int x0, input int x1, input int y0, input int y1, input int nz);
    rx0 = x0; rx1 = x1; ry0 = y0; ry1 = y1; noise_on = nz;
  endtask

  task automatic thresholds(input int p, input int a, input int d, input int mn, input int mx);
    t_proj = p; t_area = a; t_den = d; t_min = mn; t_max = mx;
  endtask

  // result monitor: R3..R9, R11 (frames arrive in order)
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_v && res_valid) chk("R9", "strobe longer than one cycle", 1, 0);
      if (res_valid) begin
        if (rcount >= NF) chk("R9", "unexpected extra result", rcount, NF - 1);
        else begin
          chk("R9",  "latency", cyc - eof_cyc[rcount], LAT);
          chk("R5",  "empty",   int'(res_empty),   e_empty[rcount]);
          chk("R3",  "x_first", int'(res_x_first), e_x0[rcount]);
          chk("R3",  "x_last",  int'(res_x_last),  e_x1[rcount]);
          chk("R3",  "y_first", int'(res_y_first), e_y0[rcount]);
          chk("R3",  "y_last",  int'(res_y_last),  e_y1[rcount]);
          chk("R3",  "width",   int'(res_width),   e_w[rcount]);
          chk("R3",  "height",  int'(res_height),  e_h[rcount]);
          chk("R4",  "area",    int'(res_area),    e_a[rcount]);
          chk("R6/R7/R8", "human", int'(res_human), e_human[rcount]);
        end
        rcount++;
      end
    end
    prev_v = res_valid;
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d results expected %0d", rcount, NF);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    noise_seed = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "res_valid", int'(res_valid), 0);
    chk("R1", "res_human", int'(res_human), 0);
    chk("R1", "res_empty", int'(res_empty), 0);
    chk("R1", "res_area",  int'(res_area),  0);
    chk("R1", "res_width", int'(res_width) + int'(res_height), 0);

    // F0: tall box; rows hold exactly proj_thr pixels (R3 inclusive), human
    shape(20, 31, 50, 89, 0); thresholds(12, 100, 4, 8, 16);
    calc_expected(0); send_frame(0, 0);
    // F1 back-to-back (R11): square box passes area and ratio, fails R8
    shape(40, 69, 10, 39, 0); thresholds(1, 100, 4, 2, 16);
    calc_expected(1); send_frame(1, 0);
    // F2 back-to-back: empty frame right after a full one (R2, R5)
    shape(200, 0, 200, 0, 0); thresholds(1, 10, 4, 2, 16);
    calc_expected(2); send_frame(2, 0);
    idle(4);
    // F3: area equals threshold, rejected (R6)
    shape(100, 103, 5, 14, 0); thresholds(1, 40, 4, 4, 16);
    calc_expected(3); send_frame(3, 0);
    idle(3);
    // F4: noisy random box, garbage in invalid cycles (R12), cfg changed after eof (R10)
    shape($urandom_range(0, 60), $urandom_range(70, 90), $urandom_range(0, 30), $urandom_range(60, 127), 1);
    noise_seed = 5;
    thresholds(3, 50, 2, 3, 10);
    calc_expected(4); send_frame(4, 16);
    @(negedge clk);
    pix_valid = 0; pix_sof = 0; pix_eof = 0;
    cfg_proj_thr = 8'd200; cfg_area_thr = 15'd0; cfg_ratio_den = 8'd1;
    cfg_ratio_min = 8'd0; cfg_ratio_max = 8'd255;   // R10: must not matter
    idle(140);
    // F5: height exactly on the lower aspect bound (R7 inclusive), human
    shape(60, 69, 30, 49, 0); noise_on = 0; thresholds(1, 100, 4, 8, 12);
    calc_expected(5); send_frame(5, 0);
    // F6 back-to-back: one row over the upper aspect bound (R7)
    shape(60, 69, 30, 60, 0); thresholds(1, 100, 4, 8, 12);
    calc_expected(6); send_frame(6, 0);
    idle(2);
    // F7: random box with noise and random thresholds
    noise_seed = 9;
    shape($urandom_range(0, 50), $urandom_range(51, 127), $urandom_range(0, 50), $urandom_range(51, 127), 1);
    thresholds($urandom_range(1, 4), $urandom_range(0, 3000), 4, $urandom_range(1, 8), $urandom_range(8, 40));
    calc_expected(7); send_frame(7, 0);
    idle(2);
    // F8: zero threshold, full 128x128 box, square so not human (R3, R4, R8)
    shape(0, -1, 0, -1, 0); thresholds(0, 5, 4, 1, 64);
    calc_expected(8); send_frame(8, 0);
    idle(LAT + 10);

    chk("R11", "results received", rcount, NF);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule